// File: doc/BRIEF.md
# Buck Gate-Drive Sequencer

This block converts a single pulse-width command into the two gate enables of a synchronous buck power stage: `gate_hi` for the high-side switch and `gate_lo` for the low-side switch. The command arrives already decoded into a level bit (`pwm_hi`) and a tri-state flag (`pwm_mid`). On every command edge the conducting switch is released first. The opposite switch is enabled only after two things have happened. First, the released gate must be sensed low through a two-flop synchronizer, or a confirmation timeout must expire. Second, a non-overlap delay must elapse, counted in clock cycles. All delays are parameters given in cycles. At 100 MHz, 250 ns is 25 cycles and 55 µs is 5500 cycles.

An active-low mode input selects continuous or diode-emulation operation. In diode-emulation mode the low-side switch is held on for a blanking window and is then released on the first cycle that the sampled zero-current flag is seen. A tri-state command that lasts beyond a holdoff count turns both switches off. Three conditions force both gates low at once: the active-low output disable, the thermal-shutdown flag and the undervoltage flag. Each rising edge of the disable input also starts a calibration interval, during which `cal_busy` is high.

The sequencer states are:
- `S_IDLE`: both gates off. Leaves on the first free cycle toward the current level.
- `S_LS_OFF_WAIT`: waits for the low-side off confirmation or timeout, then goes to `S_HS_DELAY`.
- `S_HS_DELAY`: non-overlap count, then `S_HS_ON`.
- `S_HS_ON`: high side conducting.
- `S_HS_OFF_WAIT`: waits for the high-side off confirmation or timeout, then goes to `S_LS_DELAY`.
- `S_LS_DELAY`: non-overlap count. Then `S_LS_ON` in continuous mode, or `S_LS_BLANK` in diode-emulation mode.
- `S_LS_ON`: low side held for the whole low interval.
- `S_LS_BLANK`: low side on, zero-current flag ignored. Goes to `S_LS_MON` when the window ends.
- `S_LS_MON`: low side on, watching the flag. Goes to `S_LS_PARK` when the flag is seen.
- `S_LS_PARK`: both off until the command goes high.
- `S_TRI`: both off after a long tri-state command. Goes to `S_IDLE` when it ends.

A command going high sends every low-side state and `S_LS_DELAY` to `S_LS_OFF_WAIT`. A command going low sends `S_HS_DELAY` and `S_HS_ON` to `S_HS_OFF_WAIT`. Any fault sends every state to `S_IDLE`. An expired holdoff sends every state to `S_TRI`.

Top module: `buck_gate_seq`

## Requirements
- R1: `gate_hi` and `gate_lo` are never high in the same cycle.
- R2: When the command rises, `gate_lo` falls in the same cycle. `gate_hi` rises 3+NOL_CYC cycles later when the low-side confirmation follows the gate. Two of those cycles are synchronizer flops and one is the wait state.
- R3: When the command falls, `gate_hi` falls in the same cycle. `gate_lo` rises 3+NOL_CYC cycles later under the same conditions.
- R4: With `dcm_en_n` high, `gate_lo` stays high for the whole low command interval, whatever the value of `zc_seen`.
- R5: With `dcm_en_n` low, `gate_lo` stays high for BLANK_CYC cycles while ignoring `zc_seen`. After that it falls on the first clock edge at which `zc_seen` is high, and stays low until the command rises.
- R6: A `pwm_mid` run of HOLDOFF_CYC cycles or more drives both gates low, and `pwm_hi` is ignored throughout. A shorter run leaves the outputs unchanged. When the run ends, sequencing restarts from `S_IDLE`.
- R7: Each rising edge of `disable_n` holds `cal_busy` high for exactly CAL_CYC cycles.
- R8: While `disable_n` is low or `therm_trip` is high, both gates are low from that cycle on. Sequencing resumes once the condition clears.
- R9: While `uv_trip` is high, both gates are low and the sequencer sits in `S_IDLE`. When the flag clears, sequencing restarts from the current command level, and a low command gives `gate_lo` 1+NOL_CYC cycles later.
- R10: If an off confirmation never arrives, the sequencer proceeds after NOL_CYC+8 cycles in the wait state. With a high command, `gate_hi` then rises 8+2·NOL_CYC cycles after the edge.
- R11: After a fault or disable is released with a high command, `gate_hi` rises only after the full non-overlap delay, 1+NOL_CYC cycles after release.
- R12: In reset and directly after it, both gates and `cal_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_hi | input | 1 | Decoded command level, 1 = high |
| pwm_mid | input | 1 | Decoded tri-state command, 1 = mid level |
| disable_n | input | 1 | Active-low output disable; rising edge starts calibration |
| dcm_en_n | input | 1 | Active-low diode-emulation enable |
| zc_seen | input | 1 | Sampled zero-current flag of the switch node |
| therm_trip | input | 1 | Thermal-shutdown flag |
| uv_trip | input | 1 | Undervoltage flag |
| hs_gate_low | input | 1 | High-side gate sensed low (asynchronous) |
| ls_gate_low | input | 1 | Low-side gate sensed low (asynchronous) |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| cal_busy | output | 1 | Calibration interval in progress |

## Verification
The hardest state to reach is the confirmation timeout. In normal operation the sensed gate-low signal follows the gate enable, so the wait state always leaves on the confirmation. The bench models the gate sense from the enables, and it has a stuck-low override on the low-side sense. With the override active, the next rising command can only leave `S_LS_OFF_WAIT` through the timeout. A second case is the diode-emulation blanking window. There `zc_seen` is held high from before the low-side turn-on, so an early release would show up as a shortened `gate_lo` pulse.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LS_OFF_WAIT,
        S_HS_DELAY,
        S_HS_ON,
        S_HS_OFF_WAIT,
        S_LS_DELAY,
        S_LS_ON,
        S_LS_BLANK,
        S_LS_MON,
        S_LS_PARK,
        S_TRI
    } seq_state_e;

endpackage

// File: rtl/bgs_sync2.sv
module bgs_sync2 #(
    parameter int   WIDTH   = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                stab_q <= RST_VAL;
            end else begin
                meta_q <= async_in[i];
                stab_q <= meta_q;
            end
        end

        assign sync_out[i] = stab_q;
    end

endmodule

// File: rtl/bgs_cal_timer.sv
module bgs_cal_timer #(
    parameter int CAL_CYC = 5500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic disable_n,
    output logic busy
);

    localparam int CNT_W = $clog2(CAL_CYC + 1);

    logic             dis_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;

    assign rise = disable_n && !dis_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            dis_q <= disable_n;
            if (rise) begin
                cnt_q <= CNT_W'(CAL_CYC);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy = (cnt_q != '0);

    AST_CAL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> busy); // R7

    AST_CAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rise) |=> !busy); // R7

endmodule

// File: rtl/bgs_holdoff.sv
module bgs_holdoff #(
    parameter int HOLDOFF_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    input  logic pwm_mid,
    output logic cmd_hi,
    output logic tri_exp
);

    localparam int MID_W = $clog2(HOLDOFF_CYC + 1);

    logic [MID_W-1:0] mid_cnt_q;
    logic             cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_cnt_q <= '0;
            cmd_q     <= 1'b0;
        end else if (pwm_mid) begin
            if (mid_cnt_q != MID_W'(HOLDOFF_CYC)) begin
                mid_cnt_q <= mid_cnt_q + 1'b1;
            end
        end else begin
            mid_cnt_q <= '0;
            cmd_q     <= pwm_hi;
        end
    end

    // The last valid level is kept while the command sits at mid level.
    assign cmd_hi  = pwm_mid ? cmd_q : pwm_hi;
    assign tri_exp = pwm_mid && (mid_cnt_q == MID_W'(HOLDOFF_CYC));

    AST_MID_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mid && $past(pwm_mid)) |-> $stable(cmd_hi)); // R6

endmodule

// File: rtl/bgs_phase_fsm.sv
module bgs_phase_fsm
    import buck_seq_pkg::*;
#(
    parameter int NOL_CYC   = 4,
    parameter int BLANK_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi,
    input  logic pwm_mid,
    input  logic tri_exp,
    input  logic halt,
    input  logic dcm_mode,
    input  logic zc_seen,
    input  logic conf_hs,
    input  logic conf_ls,
    output logic gate_hi,
    output logic gate_lo
);

    localparam int TMO_CYC = NOL_CYC + 8;
    localparam int TMAX    = (TMO_CYC > BLANK_CYC) ? TMO_CYC : BLANK_CYC;
    localparam int TMR_W   = $clog2(TMAX + 1);
    localparam logic [TMR_W-1:0] NOL_LAST   = TMR_W'(NOL_CYC - 1);
    localparam logic [TMR_W-1:0] TMO_LAST   = TMR_W'(TMO_CYC - 1);
    localparam logic [TMR_W-1:0] BLANK_LAST = TMR_W'(BLANK_CYC - 1);
    localparam logic [TMR_W-1:0] TMR_SAT    = TMR_W'(TMAX);

    seq_state_e       state_q, state_d;
    logic [TMR_W-1:0] tmr_q;

    // State register with the per-state cycle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                tmr_q <= '0;
            end else if (tmr_q != TMR_SAT) begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (halt) begin
            state_d = S_IDLE;
        end else if (tri_exp) begin
            state_d = S_TRI;
        end else begin
            unique case (state_q)
                S_IDLE:        state_d = cmd_hi ? S_LS_OFF_WAIT : S_HS_OFF_WAIT;
                S_LS_OFF_WAIT: begin
                    if (!cmd_hi)                           state_d = S_HS_OFF_WAIT;
                    else if (conf_ls || tmr_q == TMO_LAST) state_d = S_HS_DELAY;
                end
                S_HS_DELAY: begin
                    if (!cmd_hi)                 state_d = S_HS_OFF_WAIT;
                    else if (tmr_q == NOL_LAST)  state_d = S_HS_ON;
                end
                S_HS_ON: begin
                    if (!cmd_hi)                 state_d = S_HS_OFF_WAIT;
                end
                S_HS_OFF_WAIT: begin
                    if (cmd_hi)                            state_d = S_LS_OFF_WAIT;
                    else if (conf_hs || tmr_q == TMO_LAST) state_d = S_LS_DELAY;
                end
                S_LS_DELAY: begin
                    if (cmd_hi)                  state_d = S_LS_OFF_WAIT;
                    else if (tmr_q == NOL_LAST)  state_d = dcm_mode ? S_LS_BLANK : S_LS_ON;
                end
                S_LS_ON: begin
                    if (cmd_hi)                  state_d = S_LS_OFF_WAIT;
                end
                S_LS_BLANK: begin
                    if (cmd_hi)                  state_d = S_LS_OFF_WAIT;
                    else if (tmr_q == BLANK_LAST) state_d = S_LS_MON;
                end
                S_LS_MON: begin
                    if (cmd_hi)                  state_d = S_LS_OFF_WAIT;
                    else if (zc_seen)            state_d = S_LS_PARK;
                end
                S_LS_PARK: begin
                    if (cmd_hi)                  state_d = S_LS_OFF_WAIT;
                end
                S_TRI: begin
                    if (!pwm_mid)                state_d = S_IDLE;
                end
                default:                         state_d = S_IDLE;
            endcase
        end
    end

    // Output decode; any fault removes both enables in the same cycle.
    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        unique case (state_q)
            S_HS_ON:                     gate_hi = !halt;
            S_LS_ON, S_LS_BLANK, S_LS_MON: gate_lo = !halt;
            default: begin
                gate_hi = 1'b0;
                gate_lo = 1'b0;
            end
        endcase
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo)); // R1

    AST_HS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(state_q) == S_HS_DELAY); // R2

    AST_LS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> $past(state_q) == S_LS_DELAY); // R3

    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LS_BLANK && !cmd_hi && !halt && !tri_exp) |=> gate_lo || halt); // R5

    AST_TRI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_exp && !halt) |=> (state_q == S_TRI)); // R6

    AST_FAULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (state_q == S_IDLE)); // R9

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
    parameter int NOL_CYC     = 4,
    parameter int BLANK_CYC   = 25,
    parameter int HOLDOFF_CYC = 25,
    parameter int CAL_CYC     = 5500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    input  logic pwm_mid,
    input  logic disable_n,
    input  logic dcm_en_n,
    input  logic zc_seen,
    input  logic therm_trip,
    input  logic uv_trip,
    input  logic hs_gate_low,
    input  logic ls_gate_low,
    output logic gate_hi,
    output logic gate_lo,
    output logic cal_busy
);

    logic [1:0] conf_sync;
    logic       cmd_hi;
    logic       tri_exp;
    logic       halt;

    assign halt = !disable_n || therm_trip || uv_trip;

    bgs_sync2 #(.WIDTH(2), .RST_VAL(1'b1)) u_conf_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({hs_gate_low, ls_gate_low}),
        .sync_out (conf_sync)
    );

    bgs_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_holdoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm_hi  (pwm_hi),
        .pwm_mid (pwm_mid),
        .cmd_hi  (cmd_hi),
        .tri_exp (tri_exp)
    );

    bgs_phase_fsm #(.NOL_CYC(NOL_CYC), .BLANK_CYC(BLANK_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_hi   (cmd_hi),
        .pwm_mid  (pwm_mid),
        .tri_exp  (tri_exp),
        .halt     (halt),
        .dcm_mode (!dcm_en_n),
        .zc_seen  (zc_seen),
        .conf_hs  (conf_sync[1]),
        .conf_ls  (conf_sync[0]),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo)
    );

    bgs_cal_timer #(.CAL_CYC(CAL_CYC)) u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .disable_n (disable_n),
        .busy      (cal_busy)
    );

    AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_trip || !disable_n) |-> !gate_hi && !gate_lo); // R8

endmodule

// File: tb/buck_gate_seq_bench.sv
`timescale 1ns/1ps
module buck_gate_seq_bench;

    localparam int NOL   = 4;
    localparam int BLANK = 6;
    localparam int HOLD  = 5;
    localparam int CAL   = 40;

    logic clk = 1'b0;
    logic rst_n, pwm_hi, pwm_mid, disable_n, dcm_en_n, zc_seen, therm_trip, uv_trip;
    logic ls_stuck;
    logic hs_gate_low, ls_gate_low;
    logic gate_hi, gate_lo, cal_busy;

    always #4 clk = ~clk;

    assign hs_gate_low = !gate_hi;
    assign ls_gate_low = !gate_lo && !ls_stuck;

    buck_gate_seq #(.NOL_CYC(NOL), .BLANK_CYC(BLANK), .HOLDOFF_CYC(HOLD), .CAL_CYC(CAL)) u_buck_gate_seq (
        .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_mid(pwm_mid),
        .disable_n(disable_n), .dcm_en_n(dcm_en_n), .zc_seen(zc_seen),
        .therm_trip(therm_trip), .uv_trip(uv_trip),
        .hs_gate_low(hs_gate_low), .ls_gate_low(ls_gate_low),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .cal_busy(cal_busy)
    );

    typedef struct {
        logic [2:0] val;
        int         cyc;
        string      tag;
    } ev_t;

    ev_t        exp_q[$];
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    logic [2:0] prev = 3'b000;
    logic [2:0] cur;
    bit         done = 0;

    // Driver side: expected output tuple {gate_hi, gate_lo, cal_busy}
    // k cycles after the next clock edge.
    task automatic expect_at(input int k, input logic [2:0] v, input string tag);
        ev_t e;
        e.val = v;
        e.cyc = cyc + 1 + k;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_now(input logic [2:0] v, input string tag);
        checks++;
        if ({gate_hi, gate_lo, cal_busy} !== v) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, {gate_hi, gate_lo, cal_busy}, v);
        end
    endtask

    // Monitor: pops expected changes and compares value and cycle.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            cur = {gate_hi, gate_lo, cal_busy};
            if (gate_hi && gate_lo) begin
                checks++;
                errors++;
                $display("FAIL R1 actual=both_high expected=not_both at cycle %0d", cyc);
            end
            if (cur !== prev) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected_change actual=%b expected=%b at cycle %0d", cur, prev, cyc);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    if (e.val !== cur || e.cyc != cyc) begin
                        errors++;
                        $display("FAIL %s actual=%b@%0d expected=%b@%0d", e.tag, cur, cyc, e.val, e.cyc);
                    end
                end
                prev = cur;
            end
        end
    end

    initial begin
        rst_n = 0; pwm_hi = 0; pwm_mid = 0; disable_n = 0; dcm_en_n = 1;
        zc_seen = 0; therm_trip = 0; uv_trip = 0; ls_stuck = 0;
        idle(4);
        check_now(3'b000, "R12 in reset");
        rst_n = 1;
        idle(3);
        check_now(3'b000, "R12 after reset");

        // R7 / R11: release disable with high command
        disable_n = 1; pwm_hi = 1;
        expect_at(0, 3'b001, "R7 busy rise");
        expect_at(1 + NOL, 3'b101, "R11 gh after release");
        expect_at(CAL, 3'b100, "R7 busy length");
        idle(CAL + 5);

        // R3: falling command
        pwm_hi = 0;
        expect_at(0, 3'b000, "R3 gh off");
        expect_at(3 + NOL, 3'b010, "R3 gl on");
        idle(20);
        // R4: continuous mode ignores zc_seen
        zc_seen = 1;
        idle(10);
        check_now(3'b010, "R4 gl held");
        zc_seen = 0;

        // R2: rising command
        pwm_hi = 1;
        expect_at(0, 3'b000, "R2 gl off");
        expect_at(3 + NOL, 3'b100, "R2 gh on");
        idle(20);

        // R2 / R3: short low pulse gives no low-side pulse
        pwm_hi = 0;
        expect_at(0, 3'b000, "R3 short low gh off");
        expect_at(3 + NOL, 3'b100, "R2 short low gh back");
        idle(2);
        pwm_hi = 1;
        idle(20);

        // R10: confirmation timeout
        pwm_hi = 0;
        expect_at(0, 3'b000, "R3 gh off");
        expect_at(3 + NOL, 3'b010, "R3 gl on");
        idle(20);
        ls_stuck = 1;
        pwm_hi = 1;
        expect_at(0, 3'b000, "R10 gl off");
        expect_at(8 + 2 * NOL, 3'b100, "R10 gh after timeout");
        idle(30);
        ls_stuck = 0;
        idle(5);

        // R8 / R11: thermal shutdown
        therm_trip = 1;
        expect_at(0, 3'b000, "R8 thermal off");
        idle(10);
        therm_trip = 0;
        expect_at(1 + NOL, 3'b100, "R11 gh after thermal");
        idle(15);

        // R9: undervoltage, restart from new level
        uv_trip = 1;
        expect_at(0, 3'b000, "R9 uv off");
        idle(3);
        pwm_hi = 0;
        idle(5);
        check_now(3'b000, "R9 held idle");
        uv_trip = 0;
        expect_at(1 + NOL, 3'b010, "R9 gl after uv");
        idle(15);

        // R6: short mid level is ignored
        pwm_mid = 1; pwm_hi = 1;
        idle(HOLD - 2);
        pwm_mid = 0; pwm_hi = 0;
        idle(5);
        check_now(3'b010, "R6 short mid ignored");
        // R6: long mid level drops both gates
        pwm_mid = 1; pwm_hi = 1;
        expect_at(HOLD, 3'b000, "R6 holdoff off");
        idle(HOLD + 8);
        pwm_mid = 0;
        expect_at(2 + NOL, 3'b100, "R6 restart gh");
        idle(15);

        // R5: diode emulation, zc_seen high during blanking
        dcm_en_n = 0; zc_seen = 1; pwm_hi = 0;
        expect_at(0, 3'b000, "R5 gh off");
        expect_at(3 + NOL, 3'b010, "R5 gl on");
        expect_at(3 + NOL + BLANK + 1, 3'b000, "R5 gl drop after blank");
        idle(30);
        check_now(3'b000, "R5 parked");
        zc_seen = 0; pwm_hi = 1;
        expect_at(1 + NOL, 3'b100, "R5 gh from park");
        idle(15);
        // R5: zc_seen arrives late
        pwm_hi = 0;
        expect_at(0, 3'b000, "R5 gh off");
        expect_at(3 + NOL, 3'b010, "R5 gl on");
        idle(30);
        zc_seen = 1;
        expect_at(0, 3'b000, "R5 gl drop on zc");
        idle(5);
        zc_seen = 0; dcm_en_n = 1;
        pwm_hi = 1;
        expect_at(1 + NOL, 3'b100, "R2 gh from park");
        idle(15);

        // R8 / R7: disable pulse
        disable_n = 0;
        expect_at(0, 3'b000, "R8 disable off");
        idle(8);
        disable_n = 1;
        expect_at(0, 3'b001, "R7 busy rise");
        expect_at(1 + NOL, 3'b101, "R11 gh after disable");
        expect_at(CAL, 3'b100, "R7 busy length");
        idle(CAL + 5);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL pending actual=%0d expected=0 events left", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule